// File: doc/BRIEF.md
# Byte-Addressed Load/Store Alignment Unit

This block connects a 32-bit register datapath to a data memory that is one word wide and addressed by byte. When a store request arrives, the block turns the byte address into a word address. It raises only the byte-lane write enables that the access covers. It drives the register data onto the write bus, repeated across the lanes, so that the enables alone pick the target bytes.

When a load request arrives, the block keeps the byte offset, the size and the extension mode. One cycle later, when the synchronous memory returns the addressed word, it picks out the byte, halfword or word. A narrow value is extended to 32 bits, either with zeros or with its sign. A per-request unsigned flag chooses between the two.

Every access size must start on its natural boundary. A request that breaks this is flagged as misaligned, and it neither writes nor produces a load result. The same result path also serves the upper-immediate operation. That operation places a 16-bit immediate in the upper half of the result and clears the lower half.

Top module: `lsAlign`

## Requirements
- R1: `memWordAddr` always equals `byteAddr` shifted right by 2, in the same cycle.
- R2: Lanes are numbered big-endian: byte offset 0 maps to `memWdata[31:24]` and offset 3 maps to `[7:0]`. Bit k of `memByteEn` covers `memWdata[8k+7:8k]`. A store-byte (`reqSize` = 0) raises only enable bit 3−offset, and `memWdata` carries `storeData[7:0]` in all four lanes.
- R3: A store-halfword (`reqSize` = 1) at offset 0 raises enables 4'b1100, and at offset 2 raises 4'b0011. `memWdata` carries `storeData[15:0]` in both halves.
- R4: A store-word (`reqSize` = 2, and the unused code 3 is treated the same) raises 4'b1111, and `memWdata` equals `storeData`.
- R5: `misaligned` is 1 in the request cycle for a halfword at an odd address or a word at an address that is not a multiple of 4. Such a request raises no enable. A byte access is never misaligned, and an upper-immediate request never raises `misaligned`.
- R6: `memByteEn` is 0 whenever `reqValid` is 0, and whenever the request is a load or an upper-immediate request.
- R7: `loadValid` is 1 in exactly the cycle after an accepted load or upper-immediate request. A misaligned load produces no `loadValid`.
- R8: A byte load returns the addressed byte in bits 7:0. Bits 31:8 are copies of the byte's bit 7 when `reqUnsigned` = 0, and zeros when `reqUnsigned` = 1.
- R9: A halfword load returns the addressed halfword in bits 15:0, extended by sign or by zero according to `reqUnsigned`.
- R10: A word load returns `memRdata` unchanged, whatever the value of `reqUnsigned`.
- R11: An upper-immediate request (`reqLui` = 1, which takes priority over `reqStore`) returns `{luiImm, 16'h0000}` one cycle later, whatever the values of `memRdata`, the size and the address.
- R12: While `rstN` is low, `loadValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqLui | input | 1 | Upper-immediate request |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqUnsigned | input | 1 | Zero-extend narrow loads |
| byteAddr | input | 32 | Byte address |
| storeData | input | 32 | Register data for stores |
| luiImm | input | 16 | Immediate for the upper-immediate operation |
| memRdata | input | 32 | Memory read word, valid the cycle after a load request |
| memWordAddr | output | 30 | Word address to memory |
| memByteEn | output | 4 | Byte-lane write enables |
| memWdata | output | 32 | Lane-replicated write data |
| misaligned | output | 1 | Request violates natural alignment |
| loadValid | output | 1 | `loadData` is valid |
| loadData | output | 32 | Extended load or upper-immediate result |

## Verification
The bench places byte accesses at all four offsets, including the top of the address space, and halfword accesses at both even offsets. A design with little-endian lane numbering would fail these, because it raises the mirrored enable or returns the wrong byte. Negative and positive narrow values are loaded both signed and unsigned. This catches a design that always extends one way or that takes the sign from the wrong bit. Misaligned halfword and word requests must raise the flag, suppress the enables and withhold `loadValid`. An upper-immediate request is given a non-zero read word, which exposes a design that leaks memory data into the result.

// File: rtl/lsAlignPkg.sv
package lsAlignPkg;
  localparam int SZ_BYTE = 0;
  localparam int SZ_HALF = 1;

  typedef struct packed {
    logic isByte;
    logic isHalf;
    logic isWord;
    logic misaligned;
    logic storeEn;
    logic luiTake;
    logic rdPend;
    logic luiPend;
    logic unsQ;
    logic byteQ;
    logic halfQ;
  } ctrlStrobes_t;
endpackage

// File: rtl/lsAlignCtrl.sv
module lsAlignCtrl #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic             reqLui,
  input  logic [1:0]       reqSize,
  input  logic             reqUnsigned,
  input  logic [OFF_W-1:0] addrLow,
  output lsAlignPkg::ctrlStrobes_t strobes,
  output logic [OFF_W-1:0] offQ
);
  import lsAlignPkg::*;

  logic isByte, isHalf, isWord, misC, loadTake;
  logic rdPendQ, luiPendQ, unsQ, byteQ, halfQ;

  always_comb begin
    isByte   = (reqSize == 2'(SZ_BYTE));
    isHalf   = (reqSize == 2'(SZ_HALF));
    isWord   = !isByte && !isHalf;
    misC     = reqValid && !reqLui &&
               ((isHalf && addrLow[0]) || (isWord && (addrLow != '0)));
    loadTake = reqValid && !reqStore && !reqLui && !misC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ  <= 1'b0;
      luiPendQ <= 1'b0;
      unsQ     <= 1'b0;
      byteQ    <= 1'b0;
      halfQ    <= 1'b0;
      offQ     <= '0;
    end else begin
      rdPendQ  <= loadTake;
      luiPendQ <= reqValid && reqLui;
      if (loadTake) begin
        unsQ  <= reqUnsigned;
        byteQ <= isByte;
        halfQ <= isHalf;
        offQ  <= addrLow;
      end
    end
  end

  always_comb begin
    strobes.isByte     = isByte;
    strobes.isHalf     = isHalf;
    strobes.isWord     = isWord;
    strobes.misaligned = misC;
    strobes.storeEn    = reqValid && reqStore && !reqLui && !misC;
    strobes.luiTake    = reqValid && reqLui;
    strobes.rdPend     = rdPendQ;
    strobes.luiPend    = luiPendQ;
    strobes.unsQ       = unsQ;
    strobes.byteQ      = byteQ;
    strobes.halfQ      = halfQ;
  end

  // R7: a pending result never comes from both the load and the immediate path
  a_r7_single_result: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPendQ && luiPendQ));
  // R5: a byte request is never flagged as misaligned
  a_r5_byte_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isByte) |-> !misC);
endmodule

// File: rtl/lsAlignDatapath.sv
module lsAlignDatapath #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsAlignPkg::ctrlStrobes_t strobes,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [OFF_W-1:0]  offQ,
  input  logic [DATA_W-1:0] storeData,
  input  logic [IMM_W-1:0]  luiImm,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANES-1:0]  memByteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData
);
  logic [IMM_W-1:0] immQ;
  logic [7:0]       selByte;
  logic [15:0]      selHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) immQ <= '0;
    else if (strobes.luiTake) immQ <= luiImm;
  end

  // Store lane steering, big-endian: offset o lives in lane LANES-1-o
  always_comb begin
    int byteLane, halfLane;
    byteLane  = LANES - 1 - int'(reqOff);
    halfLane  = LANES - 2 - int'(reqOff);
    memByteEn = '0;
    if (strobes.storeEn) begin
      if (strobes.isByte) begin
        memByteEn[byteLane] = 1'b1;
      end else if (strobes.isHalf) begin
        memByteEn[halfLane]     = 1'b1;
        memByteEn[halfLane + 1] = 1'b1;
      end else begin
        memByteEn = '1;
      end
    end
    if (strobes.isByte)      memWdata = {LANES{storeData[7:0]}};
    else if (strobes.isHalf) memWdata = {(LANES/2){storeData[15:0]}};
    else                     memWdata = storeData;
  end

  // Load selection and extension, one cycle after the request
  always_comb begin
    int bIdx, hIdx;
    bIdx    = (LANES - 1 - int'(offQ)) * 8;
    hIdx    = (LANES - 2 - int'(offQ)) * 8;
    selByte = memRdata[bIdx +: 8];
    selHalf = memRdata[hIdx +: 16];
    loadData = '0;
    if (strobes.luiPend) begin
      loadData = {immQ, {(DATA_W-IMM_W){1'b0}}};
    end else if (strobes.rdPend) begin
      if (strobes.byteQ)
        loadData = {{(DATA_W-8){selByte[7] & ~strobes.unsQ}}, selByte};
      else if (strobes.halfQ)
        loadData = {{(DATA_W-16){selHalf[15] & ~strobes.unsQ}}, selHalf};
      else
        loadData = memRdata;
    end
  end

  // R5: a misaligned request never writes
  a_r5_no_write_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    strobes.misaligned |-> (memByteEn == '0));
  // R2: a byte store writes exactly one lane
  a_r2_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeEn && strobes.isByte) |-> ($countones(memByteEn) == 1));
  // R11: upper-immediate result has a clear low half
  a_r11_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.luiPend |-> (loadData[DATA_W-IMM_W-1:0] == '0));
  // R8: an unsigned byte load has a clear upper part
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdPend && strobes.byteQ && strobes.unsQ) |-> (loadData[DATA_W-1:8] == '0));
endmodule

// File: rtl/lsAlign.sv
module lsAlign #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqStore,
  input  logic                    reqLui,
  input  logic [1:0]              reqSize,
  input  logic                    reqUnsigned,
  input  logic [ADDR_W-1:0]       byteAddr,
  input  logic [DATA_W-1:0]       storeData,
  input  logic [IMM_W-1:0]        luiImm,
  input  logic [DATA_W-1:0]       memRdata,
  output logic [ADDR_W-OFF_W-1:0] memWordAddr,
  output logic [LANES-1:0]        memByteEn,
  output logic [DATA_W-1:0]       memWdata,
  output logic                    misaligned,
  output logic                    loadValid,
  output logic [DATA_W-1:0]       loadData
);
  lsAlignPkg::ctrlStrobes_t strobes;
  logic [OFF_W-1:0] offQ;

  lsAlignCtrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqLui(reqLui), .reqSize(reqSize), .reqUnsigned(reqUnsigned),
    .addrLow(byteAddr[OFF_W-1:0]), .strobes(strobes), .offQ(offQ)
  );

  lsAlignDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqOff(byteAddr[OFF_W-1:0]),
    .offQ(offQ), .storeData(storeData), .luiImm(luiImm), .memRdata(memRdata),
    .memByteEn(memByteEn), .memWdata(memWdata), .loadData(loadData)
  );

  assign memWordAddr = byteAddr[ADDR_W-1:OFF_W];
  assign misaligned  = strobes.misaligned;
  assign loadValid   = strobes.rdPend || strobes.luiPend;

  // R6: no write without a store request
  a_r6_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqStore) |-> (memByteEn == '0));
  // R7: a result only follows a non-store or upper-immediate request
  a_r7_result_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(reqValid && (!reqStore || reqLui)));
endmodule

// File: tb/lsAlign_tb.sv
module lsAlign_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqStore, reqLui, reqUnsigned;
  logic [1:0]  reqSize;
  logic [31:0] byteAddr, storeData, memRdata;
  logic [15:0] luiImm;
  logic [29:0] memWordAddr;
  logic [3:0]  memByteEn;
  logic [31:0] memWdata, loadData;
  logic        misaligned, loadValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsAlign u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqLui(reqLui), .reqSize(reqSize), .reqUnsigned(reqUnsigned),
    .byteAddr(byteAddr), .storeData(storeData), .luiImm(luiImm),
    .memRdata(memRdata), .memWordAddr(memWordAddr), .memByteEn(memByteEn),
    .memWdata(memWdata), .misaligned(misaligned), .loadValid(loadValid),
    .loadData(loadData)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic        st;
    logic        lui;
    logic [1:0]  sz;
    logic        uns;
    logic [31:0] addr;
    logic [31:0] rd;
    logic [15:0] imm;
    logic [3:0]  en;
    logic [31:0] wd;
    logic        mis;
    logic        val;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 19;
  // tag: requirement number; stores use storeData 32'hA1B2C3D4
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b1, 1'b0, 2'd0, 1'b0, 32'h100, 32'h0, 16'h0, 4'b1000, 32'hD4D4D4D4, 1'b0, 1'b0, 32'h0}, // R2 off0
    '{8'd2,  1'b1, 1'b0, 2'd0, 1'b0, 32'h103, 32'h0, 16'h0, 4'b0001, 32'hD4D4D4D4, 1'b0, 1'b0, 32'h0}, // R2 off3
    '{8'd3,  1'b1, 1'b0, 2'd1, 1'b0, 32'h202, 32'h0, 16'h0, 4'b0011, 32'hC3D4C3D4, 1'b0, 1'b0, 32'h0}, // R3 off2
    '{8'd3,  1'b1, 1'b0, 2'd1, 1'b0, 32'h200, 32'h0, 16'h0, 4'b1100, 32'hC3D4C3D4, 1'b0, 1'b0, 32'h0}, // R3 off0
    '{8'd4,  1'b1, 1'b0, 2'd2, 1'b0, 32'h304, 32'h0, 16'h0, 4'b1111, 32'hA1B2C3D4, 1'b0, 1'b0, 32'h0}, // R4
    '{8'd5,  1'b1, 1'b0, 2'd1, 1'b0, 32'h201, 32'h0, 16'h0, 4'b0000, 32'hC3D4C3D4, 1'b1, 1'b0, 32'h0}, // R5 half odd
    '{8'd5,  1'b1, 1'b0, 2'd2, 1'b0, 32'h302, 32'h0, 16'h0, 4'b0000, 32'hA1B2C3D4, 1'b1, 1'b0, 32'h0}, // R5 word off2
    '{8'd8,  1'b0, 1'b0, 2'd0, 1'b0, 32'h11, 32'h12F45678, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'hFFFFFFF4}, // R8 signed
    '{8'd8,  1'b0, 1'b0, 2'd0, 1'b1, 32'h11, 32'h12F45678, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'h000000F4}, // R8 unsigned
    '{8'd8,  1'b0, 1'b0, 2'd0, 1'b0, 32'h13, 32'h12F45678, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'h00000078}, // R8 positive
    '{8'd9,  1'b0, 1'b0, 2'd1, 1'b0, 32'h22, 32'h1234ABCD, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'hFFFFABCD}, // R9 signed
    '{8'd9,  1'b0, 1'b0, 2'd1, 1'b1, 32'h20, 32'h8001ABCD, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'h00008001}, // R9 unsigned
    '{8'd9,  1'b0, 1'b0, 2'd1, 1'b0, 32'h20, 32'h7001ABCD, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'h00007001}, // R9 positive
    '{8'd10, 1'b0, 1'b0, 2'd2, 1'b0, 32'h40, 32'hDEADBEEF, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'hDEADBEEF}, // R10
    '{8'd7,  1'b0, 1'b0, 2'd2, 1'b0, 32'h41, 32'hDEADBEEF, 16'h0, 4'b0, 32'h0, 1'b1, 1'b0, 32'h0}, // R7 misaligned word
    '{8'd7,  1'b0, 1'b0, 2'd1, 1'b0, 32'h43, 32'hDEADBEEF, 16'h0, 4'b0, 32'h0, 1'b1, 1'b0, 32'h0}, // R7 misaligned half
    '{8'd11, 1'b1, 1'b1, 2'd2, 1'b0, 32'h3, 32'h12345678, 16'hBEEF, 4'b0, 32'hA1B2C3D4, 1'b0, 1'b1, 32'hBEEF0000}, // R11
    '{8'd8,  1'b0, 1'b0, 2'd0, 1'b0, 32'h7, 32'h000000FF, 16'h0, 4'b0, 32'h0, 1'b0, 1'b1, 32'hFFFFFFFF}, // R8 off3 neg
    '{8'd1,  1'b1, 1'b0, 2'd0, 1'b0, 32'hFFFFFFFE, 32'h0, 16'h0, 4'b0010, 32'hD4D4D4D4, 1'b0, 1'b0, 32'h0}  // R1 top address
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqStore = 0; reqLui = 0; reqSize = 0; reqUnsigned = 0;
    byteAddr = 0; storeData = 0; luiImm = 0; memRdata = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R12 reset loadValid", 32'(loadValid), 32'h0);
    rstN = 1;
    @(negedge clk);
    #1;
    check("R6 idle enables", 32'(memByteEn), 32'h0);
    check("R7 idle loadValid", 32'(loadValid), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reqValid = 1; reqStore = VEC[i].st; reqLui = VEC[i].lui;
      reqSize = VEC[i].sz; reqUnsigned = VEC[i].uns; byteAddr = VEC[i].addr;
      storeData = VEC[i].st ? 32'hA1B2C3D4 : 32'h0; luiImm = VEC[i].imm;
      memRdata = 32'h0;
      #1;
      check($sformatf("R1 vec %0d word addr", i), 32'(memWordAddr), VEC[i].addr >> 2);
      check($sformatf("R%0d vec %0d byte enables", VEC[i].tag, i), 32'(memByteEn), 32'(VEC[i].en));
      check($sformatf("R%0d vec %0d misaligned", VEC[i].tag, i), 32'(misaligned), 32'(VEC[i].mis));
      if (VEC[i].st && !VEC[i].lui)
        check($sformatf("R%0d vec %0d write data", VEC[i].tag, i), memWdata, VEC[i].wd);
      @(negedge clk);
      idle();
      memRdata = VEC[i].rd;
      #1;
      check($sformatf("R7 vec %0d loadValid", i), 32'(loadValid), 32'(VEC[i].val));
      if (VEC[i].val)
        check($sformatf("R%0d vec %0d load data", VEC[i].tag, i), loadData, VEC[i].ld);
    end

    // R6: store flag without reqValid writes nothing
    @(negedge clk);
    reqStore = 1; reqSize = 2; storeData = 32'h11223344;
    #1;
    check("R6 store without valid", 32'(memByteEn), 32'h0);
    // R4: size code 3 acts as a word store
    reqValid = 1; reqSize = 3; byteAddr = 32'h50;
    #1;
    check("R4 size3 enables", 32'(memByteEn), 32'hF);
    check("R4 size3 data", memWdata, 32'h11223344);
    // R5: size code 3 at offset 1 is misaligned
    byteAddr = 32'h51;
    #1;
    check("R5 size3 misaligned", 32'(misaligned), 32'h1);
    // R10: unsigned flag has no effect on a word load
    @(negedge clk);
    idle();
    reqValid = 1; reqSize = 2; reqUnsigned = 1; byteAddr = 32'h60;
    @(negedge clk);
    idle();
    memRdata = 32'h80000001;
    #1;
    check("R10 unsigned word load", loadData, 32'h80000001);
    // R7: back-to-back loads each produce a result in the following cycle
    @(negedge clk);
    reqValid = 1; reqSize = 0; byteAddr = 32'h70;
    @(negedge clk);
    memRdata = 32'h5A000000;
    reqValid = 1; reqSize = 0; byteAddr = 32'h72; reqUnsigned = 1;
    #1;
    check("R7 first back-to-back", loadData, 32'h0000005A);
    @(negedge clk);
    idle();
    memRdata = 32'h0000C300;
    #1;
    check("R7 second back-to-back", loadData, 32'h000000C3);
    @(negedge clk);
    #1;
    check("R7 valid drops", 32'(loadValid), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule